// File: doc/BRIEF.md
# Triggered Sample Frame Serializer

This block sits after the channel multiplexer and the ADC of a multi-channel strip front-end. For every accepted level-1 trigger it sends one serial frame. The frame is a fixed run of 8-bit slots: first a header, then one digitized sample per channel in multiplexer order. The line carries one bit per clock, and the clock runs at the serial bit rate. With the default 140 slots at 160 Mbit/s, a frame lasts 7 µs. That fits inside the 10 µs mean trigger spacing of a 100 kHz trigger rate.

The trigger input comes with the pipeline address of the triggered event. If triggers arrive while a frame is on the line, they wait in a small queue, and the count of waiting triggers is visible on an output. To fill each channel slot, the block asks the sample store for one byte: it raises a request strobe together with a channel index and takes the byte presented in that same cycle. When a trigger arrives and the queue has no room for it, the trigger is dropped and a sticky flag is set.

Top module: `frame_serializer`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it falls, `serOut`, `frameValid`, `pendCnt` and `overflow` are all 0. Reset empties the queue and clears the overflow flag.
- R2: Each accepted trigger produces exactly one frame. During that frame `frameValid` stays high for an unbroken (HDR_SLOTS+NUM_CH)*8 clock cycles, and one bit is sent per cycle.
- R3: The header is HDR_SLOTS bytes long. Slots 0, 1 and 2 each carry the sync byte 0xE2. Slot 3 carries the pipeline address captured with the trigger. Slot 4 carries 0x01 if the overflow flag was set in the cycle the frame started, and 0x00 otherwise. Every remaining header slot carries 0x55.
- R4: After the header come NUM_CH sample slots, for channels 0 up to NUM_CH-1 in order. For each channel, `sampleReq` is high for one cycle with `chanIdx` set to that channel. The `sampleData` value present in that cycle becomes the content of the slot.
- R5: Each slot is sent most significant bit first.
- R6: Whenever `frameValid` is low, `serOut` is 0.
- R7: A trigger that arrives while a frame is being sent is queued. `pendCnt` gives the number of accepted triggers whose frames have not yet started. Frames go out in the order their triggers arrived.
- R8: When a trigger is waiting, its frame starts exactly one idle cycle after the previous frame ends. That idle cycle has `frameValid` and `serOut` both at 0.
- R9: A trigger that arrives while `pendCnt` equals FIFO_DEPTH, in a cycle where no frame starts, is dropped. It also sets `overflow`, which then stays at 1 until reset.
- R10: `pendCnt` never exceeds FIFO_DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock; one serial bit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| trigIn | input | 1 | Level-1 trigger, one pulse per cycle-wide trigger |
| pipeAddr | input | 8 | Pipeline address captured with the trigger |
| sampleData | input | 8 | Sample byte for the channel on `chanIdx`, valid while `sampleReq` is high |
| sampleReq | output | 1 | Fetch strobe for one channel sample |
| chanIdx | output | CH_W | Channel being fetched, 0 to NUM_CH-1 |
| serOut | output | 1 | Serial frame data, most significant bit first |
| frameValid | output | 1 | High for every bit of a frame |
| pendCnt | output | CNT_W | Number of queued triggers not yet started |
| overflow | output | 1 | Sticky flag: a trigger was dropped |

## Verification
The bench builds the block with NUM_CH = 6, HDR_SLOTS = 12 and FIFO_DEPTH = 4. A frame is then 144 cycles long, so about ten complete frames can be checked byte by byte in a short run. The queue depth is unchanged, and filling it during a single frame is enough to reach the drop case. This also exercises the error slot toggling between frames, the single idle cycle between back-to-back frames, and delivery in trigger order. The channel count is the only thing that differs from the default. Header layout, bit order and queue behaviour do not depend on it.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int BYTE_W     = 8;
  localparam int SYNC_SLOTS = 3;
  localparam int ADDR_SLOT  = 3;
  localparam int ERR_SLOT   = 4;
  localparam logic [BYTE_W-1:0] SYNC_BYTE = 8'hE2;
  localparam logic [BYTE_W-1:0] PAD_BYTE  = 8'h55;

  // strobes from the frame sequencer to the datapath
  typedef struct packed {
    logic start;     // pop a trigger and load slot 0
    logic loadNext;  // load the next slot byte
    logic shift;     // shift one bit out
    logic active;    // a frame bit is on the line
  } ctrlStrobe_t;
endpackage

// File: rtl/trig_fifo.sv
module trig_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             empty,
  output logic [CNT_W-1:0] count,
  output logic             ovfFlag
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic             full, pushOk, popOk;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign popOk  = pop && !empty;
  assign pushOk = push && (!full || popOk);
  assign dout   = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      count   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= nextPtr(wrPtr);
      if (popOk)  rdPtr <= nextPtr(rdPtr);
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && !pushOk) ovfFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
  import sertx_pkg::*;
#(
  parameter int NUM_SLOTS = 140,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int BIT_W  = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fifoEmpty,
  output ctrlStrobe_t       stb,
  output logic [SLOT_W-1:0] loadSlot
);
  typedef enum logic {ST_IDLE, ST_SEND} state_t;
  state_t            state;
  logic [BIT_W-1:0]  bitCnt;
  logic [SLOT_W-1:0] slotCnt;
  logic              lastBit, lastSlot;

  assign lastBit  = (bitCnt == BIT_W'(BYTE_W - 1));
  assign lastSlot = (slotCnt == SLOT_W'(NUM_SLOTS - 1));

  always_comb begin
    stb      = '0;
    loadSlot = '0;
    stb.active = (state == ST_SEND);
    if (state == ST_IDLE) begin
      stb.start = !fifoEmpty;
    end else if (lastBit) begin
      if (!lastSlot) begin
        stb.loadNext = 1'b1;
        loadSlot     = slotCnt + 1'b1;
      end
    end else begin
      stb.shift = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bitCnt  <= '0;
      slotCnt <= '0;
    end else if (state == ST_IDLE) begin
      if (stb.start) begin
        state   <= ST_SEND;
        bitCnt  <= '0;
        slotCnt <= '0;
      end
    end else if (lastBit) begin
      bitCnt <= '0;
      if (lastSlot) state <= ST_IDLE;
      else          slotCnt <= slotCnt + 1'b1;
    end else begin
      bitCnt <= bitCnt + 1'b1;
    end
  end
endmodule

// File: rtl/frame_dp.sv
module frame_dp
  import sertx_pkg::*;
#(
  parameter int NUM_CH    = 128,
  parameter int HDR_SLOTS = 12,
  localparam int NUM_SLOTS = HDR_SLOTS + NUM_CH,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       stb,
  input  logic [SLOT_W-1:0] loadSlot,
  input  logic [BYTE_W-1:0] headAddr,
  input  logic              ovfFlag,
  input  logic [BYTE_W-1:0] sampleData,
  output logic              sampleReq,
  output logic [CH_W-1:0]   chanIdx,
  output logic              serOut,
  output logic              frameValid
);
  logic [BYTE_W-1:0] shReg, hdrAddr, slotByte;
  logic              hdrErr, inSamples, loading;

  assign loading   = stb.start || stb.loadNext;
  assign inSamples = (loadSlot >= SLOT_W'(HDR_SLOTS));
  assign sampleReq = loading && inSamples;
  assign chanIdx   = inSamples ? CH_W'(loadSlot - SLOT_W'(HDR_SLOTS)) : '0;

  always_comb begin
    if (loadSlot < SLOT_W'(SYNC_SLOTS))      slotByte = SYNC_BYTE;
    else if (loadSlot == SLOT_W'(ADDR_SLOT)) slotByte = hdrAddr;
    else if (loadSlot == SLOT_W'(ERR_SLOT))  slotByte = {{(BYTE_W-1){1'b0}}, hdrErr};
    else if (!inSamples)                     slotByte = PAD_BYTE;
    else                                     slotByte = sampleData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg   <= '0;
      hdrAddr <= '0;
      hdrErr  <= 1'b0;
    end else begin
      if (stb.start) begin
        hdrAddr <= headAddr;
        hdrErr  <= ovfFlag;
      end
      if (loading)        shReg <= slotByte;
      else if (stb.shift) shReg <= {shReg[BYTE_W-2:0], 1'b0};
    end
  end

  assign frameValid = stb.active;
  assign serOut     = stb.active && shReg[BYTE_W-1];
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import sertx_pkg::*;
#(
  parameter int NUM_CH     = 128,
  parameter int HDR_SLOTS  = 12,
  parameter int FIFO_DEPTH = 4,
  localparam int NUM_SLOTS = HDR_SLOTS + NUM_CH,
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trigIn,
  input  logic [7:0]       pipeAddr,
  input  logic [7:0]       sampleData,
  output logic             sampleReq,
  output logic [CH_W-1:0]  chanIdx,
  output logic             serOut,
  output logic             frameValid,
  output logic [CNT_W-1:0] pendCnt,
  output logic             overflow
);
  ctrlStrobe_t       stb;
  logic [SLOT_W-1:0] loadSlot;
  logic [BYTE_W-1:0] headAddr;
  logic              fifoEmpty;

  trig_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) fifo_i (
    .clk(clk), .rst(rst), .push(trigIn), .din(pipeAddr), .pop(stb.start),
    .dout(headAddr), .empty(fifoEmpty), .count(pendCnt), .ovfFlag(overflow)
  );

  frame_ctrl #(.NUM_SLOTS(NUM_SLOTS)) ctrl_i (
    .clk(clk), .rst(rst), .fifoEmpty(fifoEmpty), .stb(stb), .loadSlot(loadSlot)
  );

  frame_dp #(.NUM_CH(NUM_CH), .HDR_SLOTS(HDR_SLOTS)) dp_i (
    .clk(clk), .rst(rst), .stb(stb), .loadSlot(loadSlot), .headAddr(headAddr),
    .ovfFlag(overflow), .sampleData(sampleData), .sampleReq(sampleReq),
    .chanIdx(chanIdx), .serOut(serOut), .frameValid(frameValid)
  );
endmodule

// File: rtl/sertx_checker.sv
module sertx_checker #(
  parameter int NUM_CH     = 128,
  parameter int HDR_SLOTS  = 12,
  parameter int FIFO_DEPTH = 4,
  localparam int NBITS = (HDR_SLOTS + NUM_CH) * 8,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             trigIn,
  input logic             sampleReq,
  input logic             serOut,
  input logic             frameValid,
  input logic [CNT_W-1:0] pendCnt,
  input logic             overflow
);
  int runLen;
  always_ff @(posedge clk) begin
    if (rst)             runLen <= 0;
    else if (frameValid) runLen <= runLen + 1;
    else                 runLen <= 0;
  end

  p_frame_len_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(frameValid) |-> runLen == NBITS);
  p_req_in_frame_r4: assert property (@(posedge clk) disable iff (rst)
    sampleReq |=> frameValid);
  p_idle_low_r6: assert property (@(posedge clk) disable iff (rst)
    !frameValid |-> !serOut);
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  p_ovf_cause_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> ($past(trigIn) && $past(pendCnt) == CNT_W'(FIFO_DEPTH)));
  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    pendCnt <= CNT_W'(FIFO_DEPTH));
endmodule

bind frame_serializer sertx_checker #(
  .NUM_CH(NUM_CH), .HDR_SLOTS(HDR_SLOTS), .FIFO_DEPTH(FIFO_DEPTH)
) chk_i (
  .clk(clk), .rst(rst), .trigIn(trigIn), .sampleReq(sampleReq), .serOut(serOut),
  .frameValid(frameValid), .pendCnt(pendCnt), .overflow(overflow)
);

// File: tb/frame_serializer_tb_top.sv
module frame_serializer_tb_top;
  localparam int NCH = 6, HDR = 12, DEPTH = 4;
  localparam int NSLOTS = NCH + HDR, NBITS = NSLOTS * 8, MAXF = 16;
  // vector table: {pipeline address, sample seed}
  localparam logic [15:0] VEC [5] = '{16'h3A00, 16'hC5FF, 16'h0081, 16'hFF5B, 16'h6C13};

  logic       clk = 1'b0, rst = 1'b1, trigIn = 1'b0;
  logic [7:0] pipeAddr = '0, seed = '0, sampleData;
  logic       sampleReq, serOut, frameValid, overflow;
  logic [2:0] chanIdx, pendCnt;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  // bench model of the sample store
  assign sampleData = 8'(chanIdx) * 8'd37 + seed;

  frame_serializer #(.NUM_CH(NCH), .HDR_SLOTS(HDR), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .trigIn(trigIn), .pipeAddr(pipeAddr),
    .sampleData(sampleData), .sampleReq(sampleReq), .chanIdx(chanIdx),
    .serOut(serOut), .frameValid(frameValid), .pendCnt(pendCnt), .overflow(overflow)
  );

  // line monitor
  logic [7:0] capBytes [MAXF][NSLOTS];
  int frameLen [MAXF];
  int gapBefore [MAXF];
  int fIdx = 0, bitPos = 0, idleRun = 0, idleViol = 0;
  bit inFrame = 0;
  always @(negedge clk) begin
    if (frameValid === 1'b1) begin
      if (!inFrame) begin
        inFrame = 1; bitPos = 0;
        if (fIdx < MAXF) gapBefore[fIdx] = idleRun;
      end
      if (fIdx < MAXF && bitPos < NBITS)
        capBytes[fIdx][bitPos/8] = {capBytes[fIdx][bitPos/8][6:0], serOut};
      bitPos++;
    end else begin
      if (inFrame) begin
        if (fIdx < MAXF) frameLen[fIdx] = bitPos;
        fIdx++; inFrame = 0; idleRun = 0;
      end
      idleRun++;
      if (serOut === 1'b1 && rst === 1'b0) idleViol++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expByte(int s, logic [7:0] a, logic e, logic [7:0] sd);
    if (s < 3) return 8'hE2;
    if (s == 3) return a;
    if (s == 4) return {7'b0, e};
    if (s < HDR) return 8'h55;
    return 8'(s - HDR) * 8'd37 + sd;
  endfunction

  task automatic trig(input logic [7:0] a);
    @(negedge clk); trigIn = 1'b1; pipeAddr = a;
    @(negedge clk); trigIn = 1'b0;
  endtask

  task automatic waitFrames(input int target);
    int t = 0;
    while (fIdx < target && t < 5000) begin @(negedge clk); t++; end
    chk(fIdx >= target, "R2 frame arrival", fIdx, target);
  endtask

  task automatic checkFrame(input int idx, input logic [7:0] a, input logic e, input logic [7:0] sd);
    chk(frameLen[idx] == NBITS, "R2 frame length", frameLen[idx], NBITS);
    for (int s = 0; s < NSLOTS; s++) begin
      // bytes are reassembled MSB first (R5)
      if (s < HDR) chk(capBytes[idx][s] == expByte(s, a, e, sd), "R3 R5 header slot",
                       capBytes[idx][s], expByte(s, a, e, sd));
      else         chk(capBytes[idx][s] == expByte(s, a, e, sd), "R4 R5 sample slot",
                       capBytes[idx][s], expByte(s, a, e, sd));
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(serOut == 0 && frameValid == 0, "R1 line after reset", {serOut, frameValid}, 0);
    chk(pendCnt == 0, "R1 pendCnt after reset", pendCnt, 0);
    chk(overflow == 0, "R1 overflow after reset", overflow, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    doReset();

    // table-driven frames, one trigger each, issued while idle
    for (int v = 0; v < 5; v++) begin
      seed = VEC[v][7:0];
      base = fIdx;
      trig(VEC[v][15:8]);
      chk(pendCnt == 1, "R7 trigger queued", pendCnt, 1);
      waitFrames(base + 1);
      checkFrame(base, VEC[v][15:8], 1'b0, seed);
    end

    // queue fill, drop, ordering and back-to-back spacing
    seed = 8'h80;
    base = fIdx;
    trig(8'h10);
    while (frameValid !== 1'b1) @(negedge clk);
    for (int k = 1; k <= 4; k++) trig(8'(8'h10 + k));
    chk(pendCnt == 4, "R7 four queued during frame", pendCnt, 4);
    chk(overflow == 0, "R9 no overflow when just full", overflow, 0);
    trig(8'h15);
    chk(pendCnt == 4, "R10 count held at depth", pendCnt, 4);
    chk(overflow == 1, "R9 overflow on drop", overflow, 1);
    waitFrames(base + 5);
    repeat (4) @(negedge clk);
    chk(fIdx == base + 5, "R9 dropped trigger sends no frame", fIdx, base + 5);
    checkFrame(base, 8'h10, 1'b0, seed);
    for (int k = 1; k <= 4; k++) begin
      checkFrame(base + k, 8'(8'h10 + k), 1'b1, seed);  // R7 order, R3 error slot
      chk(gapBefore[base + k] == 1, "R8 one idle cycle between frames", gapBefore[base + k], 1);
    end
    chk(pendCnt == 0, "R7 queue drained", pendCnt, 0);
    chk(overflow == 1, "R9 overflow sticky", overflow, 1);
    chk(idleViol == 0, "R6 idle line low", idleViol, 0);

    doReset();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule